// File: doc/BRIEF.md
# DMA Bus-Mastership Acquisition Controller

This block sits in a peripheral that has to take over a shared, daisy-chained bus so it can move data on its own. The device's internal logic raises a level request. The controller then asserts the non-processor request line and waits for the chained grant to arrive from upstream. A grant that this device did not ask for is passed on to the next slot. A grant that it did ask for is kept, and the controller answers it with a selection acknowledge. Once the bus has gone quiet, the controller asserts bus-busy and signals mastership to an external transfer engine. When that engine reports it is done, the controller lets go of the bus.

All bus inputs are active-high received copies. They pass through a multi-stage synchronizer into the system clock domain. The capture-or-forward choice is made on the rising edge of the synchronized grant. The copy sent downstream is taken from a further delay line, so any unsettled decision has time to resolve before it gates the outgoing grant. Once a device has started passing a grant along, it never takes that grant back. A request that arrives while a forwarded grant is up simply waits for the next grant. There is no data stream at this boundary, so every pin is a plain level.

Top module: `dma_bus_master_acq`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `req_o`, `grant_out_o`, `sel_ack_o`, `busy_o` and `master_o` are all 0.
- R2: When `want_bus_i` is high in the idle state, `req_o` goes high at the next clock edge. It stays high until a grant is captured.
- R3: The capture decision is made once, at the rising edge of the synchronized incoming grant. The grant is captured only if `req_o` is already high on that edge and no grant is being forwarded. Counted from the falling clock edges at which the inputs are driven, a request raised up to one cycle after the grant still captures it, and a request raised two cycles after it does not. A captured grant never appears on `grant_out_o`.
- R4: Once `grant_out_o` has gone high, it stays high until the delayed copy of the incoming grant falls or INIT is seen. A request raised during that time leaves the forwarded grant in place and is served by the next grant.
- R5: On capture, `sel_ack_o` rises at the same clock edge at which `req_o` falls.
- R6: After acknowledging, the controller asserts `busy_o` and `master_o` only once the synchronized incoming grant, bus-busy and slave-sync inputs are all low. This happens three edges after the last of those inputs is driven low. Both outputs then stay high together with `sel_ack_o`.
- R7: When `xfer_done_i` is high during mastership, `sel_ack_o`, `busy_o` and `master_o` are low after the next edge. The controller returns to idle and its capture decision is cleared.
- R8: After the synchronized INIT is seen, every output is low within one clock, which is three edges after `bus_init_i` is driven. The controller returns to idle and its capture decision is cleared.
- R9: A forwarded grant reaches `grant_out_o` SYNC_STAGES + GRANT_DELAY + 1 edges after `grant_in_i` rises. With the default values this is five edges.
- R10: `grant_out_o` is low whenever the delayed copy of the incoming grant is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| want_bus_i | input | 1 | Internal level request for the bus |
| xfer_done_i | input | 1 | Completion indication from the transfer engine |
| bus_init_i | input | 1 | Received bus INIT |
| grant_in_i | input | 1 | Received chained grant from upstream |
| bus_busy_i | input | 1 | Received bus-busy |
| slave_sync_i | input | 1 | Received slave-sync |
| req_o | output | 1 | Transmitted non-processor request |
| grant_out_o | output | 1 | Chained grant sent to the next slot |
| sel_ack_o | output | 1 | Transmitted selection acknowledge |
| busy_o | output | 1 | Transmitted bus-busy |
| master_o | output | 1 | Mastership indication to the transfer engine |

## Verification
The assertions check the following on every cycle: the forwarded grant and the capture decision are never active at the same time, the forwarded grant never falls while its delayed source is still high, acknowledge rises only after a won decision, bus-busy rises only from a quiet bus, and release and INIT clear the outputs. Only the bench scenarios can show the exact race boundary between request and grant, where a one-cycle lag still wins and a two-cycle lag loses. The same holds for the precise forwarding and mastership latencies, and for the fact that a decision cleared by release or INIT lets a later grant pass downstream.

// File: rtl/dmaacq_pkg.sv
package dmaacq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQUEST,
    ST_ACKED_WAIT_IDLE,
    ST_MASTER,
    ST_RELEASE
  } acq_state_e;

  localparam int unsigned BUS_IN_W = 4;
  localparam int unsigned IX_INIT  = 0;
  localparam int unsigned IX_GRANT = 1;
  localparam int unsigned IX_BUSY  = 2;
  localparam int unsigned IX_SSYN  = 3;
endpackage

// File: rtl/dmaacq_sync.sv
module dmaacq_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dmaacq_grant_path.sv
module dmaacq_grant_path #(
  parameter int unsigned GRANT_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_s,
  input  logic init_s,
  input  logic req_active,
  input  logic clear_i,
  output logic grant_fwd_o,
  output logic won_o,
  output logic grant_late_o
);
  logic                   grant_prev_q;
  logic [GRANT_DELAY-1:0] late_q;
  logic                   won_q, won_d;
  logic                   fwd_q, fwd_d;
  logic                   grant_rise;

  assign grant_rise = grant_s & ~grant_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_prev_q <= 1'b0;
    else        grant_prev_q <= grant_s;
  end

  if (GRANT_DELAY == 1) begin : g_dly_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) late_q <= '0;
      else        late_q <= grant_s;
    end
  end else begin : g_dly_many
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) late_q <= '0;
      else        late_q <= {late_q[GRANT_DELAY-2:0], grant_s};
    end
  end

  assign grant_late_o = late_q[GRANT_DELAY-1];

  always_comb begin
    won_d = won_q;
    if (init_s || clear_i)                    won_d = 1'b0;
    else if (grant_rise && req_active && !fwd_q) won_d = 1'b1;
  end

  assign fwd_d = grant_late_o & ~won_d & ~init_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      won_q <= 1'b0;
      fwd_q <= 1'b0;
    end else begin
      won_q <= won_d;
      fwd_q <= fwd_d;
    end
  end

  assign won_o       = won_q;
  assign grant_fwd_o = fwd_q;

  // R3: a kept grant is never passed on
  p_fwd_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_q && won_q));

  // R4: forwarding ends only with its delayed source or INIT
  p_no_retract_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fwd_q) |-> $past(!grant_late_o || init_s));

  // R10: forwarding is only started by the delayed grant
  p_fwd_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_q) |-> $past(grant_late_o));
endmodule

// File: rtl/dmaacq_fsm.sv
module dmaacq_fsm
  import dmaacq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic want_bus_i,
  input  logic xfer_done_i,
  input  logic init_s,
  input  logic grant_s,
  input  logic busy_s,
  input  logic ssyn_s,
  input  logic won_i,
  input  logic grant_late_i,
  output logic req_o,
  output logic sel_ack_o,
  output logic busy_o,
  output logic master_o,
  output logic release_o
);
  acq_state_e state_q, state_d;
  logic       bus_quiet;

  assign bus_quiet = !grant_s && !busy_s && !ssyn_s;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:            if (want_bus_i)             state_d = ST_REQUEST;
      ST_REQUEST:         if (won_i && grant_late_i)  state_d = ST_ACKED_WAIT_IDLE;
      ST_ACKED_WAIT_IDLE: if (bus_quiet)              state_d = ST_MASTER;
      ST_MASTER:          if (xfer_done_i)            state_d = ST_RELEASE;
      ST_RELEASE:                                     state_d = ST_IDLE;
      default:                                        state_d = ST_IDLE;
    endcase
    if (init_s) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_o     = (state_q == ST_REQUEST);
  assign sel_ack_o = (state_q == ST_ACKED_WAIT_IDLE) || (state_q == ST_MASTER);
  assign busy_o    = (state_q == ST_MASTER);
  assign master_o  = (state_q == ST_MASTER);
  assign release_o = (state_q == ST_MASTER) && xfer_done_i && !init_s;

  // R2: an idle request is raised on the next edge
  p_req_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && want_bus_i && !init_s) |=> req_o);

  // R5: acknowledge only follows a won, delayed grant
  p_ack_after_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_ack_o) |-> $past(won_i && grant_late_i));

  // R5: request drops only into acknowledge, unless INIT
  p_req_to_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req_o) && !$past(init_s)) |-> sel_ack_o);

  // R6: bus-busy is taken only from a quiet bus
  p_master_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(!grant_s && !busy_s && !ssyn_s));

  // R7: completion drops the bus on the next edge
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (master_o && xfer_done_i) |=> (!busy_o && !sel_ack_o && !master_o));
endmodule

// File: rtl/dma_bus_master_acq.sv
module dma_bus_master_acq
  import dmaacq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GRANT_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_bus_i,
  input  logic xfer_done_i,
  input  logic bus_init_i,
  input  logic grant_in_i,
  input  logic bus_busy_i,
  input  logic slave_sync_i,
  output logic req_o,
  output logic grant_out_o,
  output logic sel_ack_o,
  output logic busy_o,
  output logic master_o
);
  logic [BUS_IN_W-1:0] raw_in, syn_in;
  logic init_s, grant_s, busy_s, ssyn_s;
  logic won, grant_late, release_pulse;

  always_comb begin
    raw_in           = '0;
    raw_in[IX_INIT]  = bus_init_i;
    raw_in[IX_GRANT] = grant_in_i;
    raw_in[IX_BUSY]  = bus_busy_i;
    raw_in[IX_SSYN]  = slave_sync_i;
  end

  dmaacq_sync #(.WIDTH(BUS_IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_in),
    .sync_o  (syn_in)
  );

  assign init_s  = syn_in[IX_INIT];
  assign grant_s = syn_in[IX_GRANT];
  assign busy_s  = syn_in[IX_BUSY];
  assign ssyn_s  = syn_in[IX_SSYN];

  dmaacq_grant_path #(.GRANT_DELAY(GRANT_DELAY)) u_grant (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant_s      (grant_s),
    .init_s       (init_s),
    .req_active   (req_o),
    .clear_i      (release_pulse),
    .grant_fwd_o  (grant_out_o),
    .won_o        (won),
    .grant_late_o (grant_late)
  );

  dmaacq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .want_bus_i   (want_bus_i),
    .xfer_done_i  (xfer_done_i),
    .init_s       (init_s),
    .grant_s      (grant_s),
    .busy_s       (busy_s),
    .ssyn_s       (ssyn_s),
    .won_i        (won),
    .grant_late_i (grant_late),
    .req_o        (req_o),
    .sel_ack_o    (sel_ack_o),
    .busy_o       (busy_o),
    .master_o     (master_o),
    .release_o    (release_pulse)
  );

  // R8: synchronized INIT silences every output within one clock
  p_init_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_s |=> (!req_o && !grant_out_o && !sel_ack_o && !busy_o && !master_o));
endmodule

// File: tb/dma_bus_master_acq_bench.sv
module dma_bus_master_acq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic want_bus_i = 0, xfer_done_i = 0, bus_init_i = 0;
  logic grant_in_i = 0, bus_busy_i = 0, slave_sync_i = 0;
  logic req_o, grant_out_o, sel_ack_o, busy_o, master_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_bus_master_acq u_dma_bus_master_acq (
    .clk(clk), .rst_n(rst_n), .want_bus_i(want_bus_i), .xfer_done_i(xfer_done_i),
    .bus_init_i(bus_init_i), .grant_in_i(grant_in_i), .bus_busy_i(bus_busy_i),
    .slave_sync_i(slave_sync_i), .req_o(req_o), .grant_out_o(grant_out_o),
    .sel_ack_o(sel_ack_o), .busy_o(busy_o), .master_o(master_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit expect_capture(input int want_t, input int grant_t);
    return want_t <= grant_t + 1;
  endfunction

  function automatic int outs();
    return {27'd0, req_o, grant_out_o, sel_ack_o, busy_o, master_o};
  endfunction

  // one arbitration: request/grant race, quiet wait, mastership, release
  task automatic run_arb(input int want_t, input int grant_t, input int hb,
                         input int hs, input int mh);
    bit cap = expect_capture(want_t, grant_t);
    bit fwd_seen = 0, retract = 0, leaked = 0;
    int span = ((want_t > grant_t) ? want_t : grant_t) + 8;
    int last = (hb > hs) ? hb : hs;
    bus_busy_i = 1; slave_sync_i = 1;
    for (int c = 0; c <= span; c++) begin
      if (c == want_t)  want_bus_i = 1;
      if (c == grant_t) grant_in_i = 1;
      tick(1);
      if (c + 1 == want_t + 1) chk(req_o == 1, "R2 request raised", req_o, 1);
      if (!cap && c + 1 == grant_t + 4) chk(grant_out_o == 0, "R9 not yet forwarded", grant_out_o, 0);
      if (!cap && c + 1 == grant_t + 5) chk(grant_out_o == 1, "R9 forwarded on time", grant_out_o, 1);
      if (grant_out_o) fwd_seen = 1;
      if (fwd_seen && !grant_out_o && grant_in_i) retract = 1;
    end
    if (cap) begin
      chk(!fwd_seen, "R3 kept grant not passed", fwd_seen, 0);
      chk(sel_ack_o == 1, "R5 acknowledge", sel_ack_o, 1);
      chk(req_o == 0, "R5 request dropped", req_o, 0);
    end else begin
      chk(fwd_seen && !retract, "R4 forwarded grant held", retract, 0);
      chk(sel_ack_o == 0, "R3 no acknowledge on lost race", sel_ack_o, 0);
      chk(req_o == 1, "R2 request still held", req_o, 1);
      grant_in_i = 0;
      tick(6);
      chk(grant_out_o == 0, "R10 forward follows grant low", grant_out_o, 0);
      grant_in_i = 1;
      for (int k = 0; k < 8; k++) begin
        tick(1);
        if (grant_out_o) leaked = 1;
      end
      chk(!leaked, "R3 second grant kept", leaked, 0);
      chk(sel_ack_o == 1 && req_o == 0, "R5 ack on second grant", outs(), 32'h04);
    end
    for (int k = 0; k <= last + 2; k++) begin
      if (k == 0)  grant_in_i = 0;
      if (k == hb) bus_busy_i = 0;
      if (k == hs) slave_sync_i = 0;
      tick(1);
      if (k + 1 <= last + 2) chk(master_o == 0, "R6 waits for quiet bus", master_o, 0);
      else chk(master_o == 1 && busy_o == 1, "R6 mastership taken", outs(), 32'h07);
    end
    want_bus_i = 0;
    tick(mh);
    chk(master_o && busy_o && sel_ack_o, "R6 mastership held", outs(), 32'h07);
    xfer_done_i = 1;
    tick(1);
    xfer_done_i = 0;
    chk(!busy_o && !sel_ack_o && !master_o, "R7 released", outs(), 0);
    tick(3);
    chk(outs() == 0, "R7 idle after release", outs(), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    tick(2);
    chk(outs() == 0, "R1 outputs in reset", outs(), 0);
    rst_n = 1;
    tick(1);
    chk(outs() == 0, "R1 outputs after reset", outs(), 0);

    // directed race boundaries (R3)
    run_arb(3, 2, 1, 2, 2);   // request one cycle late: still captured
    run_arb(4, 2, 0, 0, 1);   // request two cycles late: forwarded
    run_arb(1, 5, 3, 0, 3);   // request well ahead

    // INIT during mastership (R8)
    run_arb(1, 1, 0, 0, 1);
    want_bus_i = 1; bus_busy_i = 0; slave_sync_i = 0;
    tick(1); grant_in_i = 1;
    tick(8); grant_in_i = 0;
    tick(4); want_bus_i = 0;
    chk(master_o == 1, "R6 master before INIT", master_o, 1);
    bus_init_i = 1;
    tick(2);
    chk(master_o == 1, "R8 INIT not yet seen", master_o, 1);
    tick(1);
    chk(outs() == 0, "R8 INIT clears outputs", outs(), 0);
    bus_init_i = 0;
    tick(4);
    chk(outs() == 0, "R8 stays idle", outs(), 0);

    // INIT while acknowledged clears the decision (R8)
    want_bus_i = 1; bus_busy_i = 1;
    tick(2); grant_in_i = 1;
    tick(8);
    chk(sel_ack_o == 1, "R5 acknowledged before INIT", sel_ack_o, 1);
    bus_init_i = 1; want_bus_i = 0;
    tick(3);
    chk(outs() == 0, "R8 INIT drops acknowledge", outs(), 0);
    bus_init_i = 0; grant_in_i = 0; bus_busy_i = 0;
    tick(6); grant_in_i = 1;
    tick(6);
    chk(grant_out_o == 1, "R8 decision cleared, grant passes", grant_out_o, 1);
    bus_init_i = 1;
    tick(3);
    chk(grant_out_o == 0, "R8 INIT stops forwarding", grant_out_o, 0);
    bus_init_i = 0; grant_in_i = 0;
    tick(6);
    chk(grant_out_o == 0, "R10 no grant, no forward", grant_out_o, 0);

    // constrained random races and bus activity
    for (int i = 0; i < 40; i++) begin
      int wt = 1 + int'($urandom % 6);
      int gt = 1 + int'($urandom % 6);
      int hb = int'($urandom % 6);
      int hs = int'($urandom % 6);
      int mh = 1 + int'($urandom % 6);
      run_arb(wt, gt, hb, hs, mh);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end
endmodule